// File: doc/BRIEF.md
# BT.656 timing reference decoder

This block watches a multiplexed 4:2:2 YCbCr word stream on a single bus, 8 or 10 bits wide, that is sampled on the rising edge of the 27 MHz video clock. It picks out the embedded timing codes that open and close each active line. Each code is four words: an all-ones word, two all-zero words, then a status word. From the status word it takes the field, vertical-blanking and horizontal-blanking bits. It checks them against four parity bits and repairs any single-bit error.

The decoder drives registered horizontal sync, vertical sync and field levels from the codes it accepts. When a status word cannot be repaired, it raises an error pulse and leaves the sync levels unchanged. It also produces a qualifier that marks the words of active video, and a tag that gives the component carried by each of those words. A downstream pixel path uses the tag to split luma from chroma without a second counter.

Top module: `bt656_timing_decoder`

## Requirements
- R1: While rst_ni is low, every output is 0.
- R2: A code is found when three consecutive words are all-ones in every bit, then zero, then zero. The next word is the status word. Its top eight bits are, from MSB down: a constant, F, V, H, P3, P2, P1, P0, with P3=V^H, P2=F^H, P1=F^V and P0=F^V^H. Any bits below those eight are ignored. One cycle after the status word is sampled, field_o, vsync_o and hsync_o show F, V and H. They change at no other time.
- R3: A status word whose seven F/V/H/P bits lie at Hamming distance one from a valid pattern is taken as that valid pattern, and err_o stays 0. The constant MSB is not checked.
- R4: A status word at distance two or more from every valid pattern gives a one-cycle err_o pulse one cycle later. It leaves field_o, vsync_o, hsync_o and active_o unchanged, and the word is not treated as a code.
- R5: An accepted code with H=0 (start of line) sets active_o to the inverse of its V bit, starting the next cycle.
- R6: An accepted code with H=1 (end of line) clears active_o from the next cycle on.
- R7: phase_o encodes 0=Cb, 1=Y, 2=Cr, 3=Y. It is 0 on the first active word after a start code and steps by one (mod 4) on each later active word. It is 0 while active_o is low.
- R8: With DATA_W=8, the decoder behaves exactly like the 10-bit build when fed the top eight bits of the same stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 27 MHz video word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Multiplexed video word |
| field_o | output | 1 | Field bit of last accepted code |
| vsync_o | output | 1 | Vertical blanking bit of last accepted code |
| hsync_o | output | 1 | Horizontal blanking bit of last accepted code |
| active_o | output | 1 | Current word is active video |
| phase_o | output | 2 | Component tag of the current word |
| err_o | output | 1 | Uncorrectable status word seen |

## Verification
Parity repair and line framing can land in the same cycle. This happens when a start or end code with one flipped bit must both be corrected and open or close the qualifier. The bench flips each of the seven protected bits in turn on both code kinds. A cycle model that searches for the nearest valid pattern decides whether active_o moves and which flags appear. Double-bit errors are also sent while the qualifier is open, and the model requires the qualifier and the phase count to carry on as if no code had come.

// File: rtl/bt656_pkg.sv
package bt656_pkg;
  localparam int XY_W = 8;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } tc_flags_t;

  localparam logic [1:0] PH_CB = 2'd0;
  localparam logic [1:0] PH_Y0 = 2'd1;
  localparam logic [1:0] PH_CR = 2'd2;
  localparam logic [1:0] PH_Y1 = 2'd3;
endpackage

// File: rtl/bt656_preamble_det.sv
module bt656_preamble_det #(
  parameter int DATA_W   = 10,
  parameter int LEAD_LEN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o
);
  localparam logic [DATA_W-1:0] ONES  = '1;
  localparam logic [DATA_W-1:0] ZEROS = '0;

  logic [DATA_W-1:0] hist_q [LEAD_LEN];

  // hist_q[0] is the newest past word, hist_q[LEAD_LEN-1] the oldest
  for (genvar g = 0; g < LEAD_LEN; g++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     hist_q[g] <= ZEROS;
      else if (g == 0) hist_q[g] <= data_i;
      else             hist_q[g] <= hist_q[g-1];
    end
  end

  always_comb begin
    hit_o = (hist_q[LEAD_LEN-1] == ONES);
    for (int i = 0; i < LEAD_LEN-1; i++) begin
      if (hist_q[i] != ZEROS) hit_o = 1'b0;
    end
  end
endmodule

// File: rtl/bt656_xy_decode.sv
module bt656_xy_decode
  import bt656_pkg::*;
(
  input  logic [XY_W-1:0] xy_i,
  output tc_flags_t       flags_o,
  output logic            bad_o
);
  logic       f, v, h;
  logic [3:0] chk, syn;

  assign f = xy_i[6];
  assign v = xy_i[5];
  assign h = xy_i[4];
  assign chk = {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  assign syn = xy_i[3:0] ^ chk;

  always_comb begin
    flags_o = '{f: f, v: v, h: h};
    bad_o   = 1'b0;
    unique case (syn)
      4'b0000, 4'b1000, 4'b0100, 4'b0010, 4'b0001: ;
      4'b0111: flags_o.f = ~f;
      4'b1011: flags_o.v = ~v;
      4'b1101: flags_o.h = ~h;
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/bt656_timing_regs.sv
module bt656_timing_regs
  import bt656_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic       bad_i,
  input  tc_flags_t  flags_i,
  output logic       field_o,
  output logic       vsync_o,
  output logic       hsync_o,
  output logic       active_o,
  output logic [1:0] phase_o,
  output logic       err_o
);
  logic       good, sav, eav, act_d;
  logic [1:0] ph_d;

  always_comb begin
    good  = hit_i && !bad_i;
    sav   = good && !flags_i.h;
    eav   = good && flags_i.h;
    act_d = active_o;
    if (sav)      act_d = !flags_i.v;
    else if (eav) act_d = 1'b0;
    ph_d = PH_CB;
    if (act_d && active_o && !sav) ph_d = phase_o + 2'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_o  <= 1'b0;
      vsync_o  <= 1'b0;
      hsync_o  <= 1'b0;
      active_o <= 1'b0;
      phase_o  <= PH_CB;
      err_o    <= 1'b0;
    end else begin
      if (good) begin
        field_o <= flags_i.f;
        vsync_o <= flags_i.v;
        hsync_o <= flags_i.h;
      end
      active_o <= act_d;
      phase_o  <= ph_d;
      err_o    <= hit_i && bad_i;
    end
  end

  AST_FLAGS_ONLY_ON_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({field_o, vsync_o, hsync_o}) |-> $past(hit_i)); // R2
  AST_ERR_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable({field_o, vsync_o, hsync_o})); // R4
  AST_ERR_KEEPS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(active_o)); // R4
  AST_RISE_NEEDS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(hit_i && !bad_i)); // R5
  AST_FALL_NEEDS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> $past(hit_i)); // R6
  AST_RISE_AT_CB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> phase_o == PH_CB); // R7
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && $past(active_o) && !$past(hit_i)) |-> phase_o == $past(phase_o) + 2'd1); // R7
endmodule

// File: rtl/bt656_timing_decoder.sv
module bt656_timing_decoder
  import bt656_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              field_o,
  output logic              vsync_o,
  output logic              hsync_o,
  output logic              active_o,
  output logic [1:0]        phase_o,
  output logic              err_o
);
  localparam int LEAD_LEN = 3;
  localparam int XY_LSB   = DATA_W - XY_W;

  logic            hit, bad;
  logic [XY_W-1:0] xy;
  tc_flags_t       flags;

  assign xy = data_i[DATA_W-1:XY_LSB];

  bt656_preamble_det #(.DATA_W(DATA_W), .LEAD_LEN(LEAD_LEN)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .data_i(data_i),
    .hit_o (hit)
  );

  bt656_xy_decode u_xy (
    .xy_i   (xy),
    .flags_o(flags),
    .bad_o  (bad)
  );

  bt656_timing_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .bad_i   (bad),
    .flags_i (flags),
    .field_o (field_o),
    .vsync_o (vsync_o),
    .hsync_o (hsync_o),
    .active_o(active_o),
    .phase_o (phase_o),
    .err_o   (err_o)
  );

  AST_ERR_ONLY_ON_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(hit)); // R4
endmodule

// File: tb/sim_bt656_timing_decoder.sv
module sim_bt656_timing_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] din = 10'h200;
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  logic f0, v0, h0, a0, e0, f1, v1, h1, a1, e1;
  logic [1:0] p0, p1;

  always #(CLK_PERIOD/2) clk = ~clk;

  bt656_timing_decoder #(.DATA_W(10)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(din),
    .field_o(f0), .vsync_o(v0), .hsync_o(h0), .active_o(a0), .phase_o(p0), .err_o(e0));

  bt656_timing_decoder #(.DATA_W(8)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(din[9:2]),
    .field_o(f1), .vsync_o(v1), .hsync_o(h1), .active_o(a1), .phase_o(p1), .err_o(e1));

  // reference model state
  logic [9:0] hq [$];
  logic mf = 0, mv = 0, mh = 0, ma = 0, me = 0;
  int   mp = 0;

  function automatic logic [7:0] xy_of(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic model_step(input logic [9:0] w);
    logic is_code, found;
    logic [2:0] fvh;
    found = 0;
    fvh = 0;
    is_code = (hq.size() == 3) && hq[0] == 10'h3FF && hq[1] == 10'h000 && hq[2] == 10'h000;
    if (is_code) begin
      for (int c = 0; c < 8; c++) begin
        logic [7:0] cw;
        cw = xy_of(c[2], c[1], c[0]);
        if ($countones(cw[6:0] ^ w[8:2]) <= 1) begin
          found = 1;
          fvh = c[2:0];
        end
      end
    end
    me = is_code && !found;
    if (is_code && found) begin
      {mf, mv, mh} = fvh;
      if (!fvh[0]) begin
        ma = !fvh[1];
        mp = 0;
      end else begin
        ma = 0;
        mp = 0;
      end
    end else if (ma) begin
      mp = (mp + 1) % 4;
    end else begin
      mp = 0;
    end
    hq.push_back(w);
    if (hq.size() > 3) void'(hq.pop_front());
  endtask

  task automatic cmp(input string pre, input logic f, input logic v, input logic h,
                     input logic a, input logic [1:0] p, input logic e);
    vectors++;
    if ({f, v, h} !== {mf, mv, mh}) begin
      fails++;
      $display("FAIL %s R2/R3 flags fvh=%b%b%b exp=%b%b%b", pre, f, v, h, mf, mv, mh);
    end
    if (e !== me) begin
      fails++;
      $display("FAIL %s R4 err_o=%b exp=%b", pre, e, me);
    end
    if (a !== ma) begin
      fails++;
      $display("FAIL %s R5/R6 active_o=%b exp=%b", pre, a, ma);
    end
    if (p !== mp[1:0]) begin
      fails++;
      $display("FAIL %s R7 phase_o=%0d exp=%0d", pre, p, mp);
    end
  endtask

  task automatic put_word(input logic [9:0] w);
    @(negedge clk);
    cmp("w10", f0, v0, h0, a0, p0, e0);
    cmp("R8", f1, v1, h1, a1, p1, e1);
    model_step(w);
    din = w;
  endtask

  task automatic blank(input int n);
    for (int i = 0; i < n; i++) put_word((i % 2) ? 10'h040 : 10'h200);
  endtask

  task automatic act(input int n);
    for (int i = 0; i < n; i++) put_word(10'h100 + 10'(i * 37));
  endtask

  task automatic put_code(input logic f, input logic v, input logic h,
                          input logic [7:0] flip, input logic [1:0] lo);
    put_word(10'h3FF);
    put_word(10'h000);
    put_word(10'h000);
    put_word({xy_of(f, v, h) ^ flip, lo});
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      vectors++;
      if ({f0, v0, h0, a0, p0, e0, f1, v1, h1, a1, p1, e1} !== 14'b0) begin
        fails++;
        $display("FAIL R1 reset outputs=%b exp=0",
                 {f0, v0, h0, a0, p0, e0, f1, v1, h1, a1, p1, e1});
      end
    end
    rst_n = 1'b1;
    blank(6);
    // R2, R5, R6, R7: clean lines over all F/V combinations, low bits varied
    for (int k = 0; k < 4; k++) begin
      put_code(k[1], k[0], 1'b1, 8'h00, 2'(k));
      blank(5);
      put_code(k[1], k[0], 1'b0, 8'h00, 2'b10);
      act(10);
    end
    // R3: single flips on start codes (correction and qualifier open together)
    for (int b = 0; b < 8; b++) begin
      put_code(1'b1, 1'b0, 1'b1, 8'h00, 2'b00);
      blank(3);
      put_code(1'b1, 1'b0, 1'b0, 8'(1 << b), 2'b00);
      act(7);
    end
    // R3: single flips on end codes
    for (int b = 0; b < 7; b++) begin
      put_code(1'b0, 1'b0, 1'b1, 8'(1 << b), 2'b01);
      blank(3);
      put_code(1'b0, 1'b0, 1'b0, 8'h00, 2'b00);
      act(5);
    end
    // R4: double flips on an end code while active, then on a start code while idle
    put_code(1'b0, 1'b0, 1'b1, 8'h03, 2'b00);
    act(6);
    put_code(1'b1, 1'b1, 1'b0, 8'h60, 2'b00);
    act(3);
    put_code(1'b0, 1'b0, 1'b1, 8'h00, 2'b00);
    put_code(1'b0, 1'b0, 1'b0, 8'h50, 2'b00);
    blank(4);
    put_code(1'b0, 1'b0, 1'b0, 8'h0C, 2'b00);
    blank(2);
    // R5: start code with V=1 keeps qualifier low
    put_code(1'b1, 1'b1, 1'b0, 8'h00, 2'b00);
    blank(4);
    // R7: start code inside an open line restarts the tag
    put_code(1'b0, 1'b0, 1'b0, 8'h00, 2'b00);
    act(5);
    put_code(1'b0, 1'b0, 1'b0, 8'h00, 2'b00);
    act(6);
    // R5: V=1 start code closes an open line
    put_code(1'b0, 1'b1, 1'b0, 8'h00, 2'b00);
    blank(3);
    put_code(1'b0, 1'b0, 1'b1, 8'h00, 2'b00);
    blank(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule